// File: doc/BRIEF.md
# Instruction-Rate Prescaler with Three Selectable Taps

This block derives the slow clock enables that a small controller's timer, its serial shifter and its clock-output pad need. The oscillator clock is first split into instruction cycles of six oscillator periods each. A 12-bit counter then advances once per instruction cycle. Three taps read that counter, and each tap has its own 4-bit selection code. Each code picks a power-of-two division of the instruction rate from 1/2 down to 1/4096.

The timer and serial taps deliver single-clock enable pulses. The clock-output tap delivers a 50% duty square wave for the pad. That wave reaches the pad only while the shared pad is not in use for the serial function. Codes outside the legal range silence the tap they select. The asynchronous active-low reset is released through a two-stage synchronizer, so counting starts a fixed number of edges after release.

Top module: `icyc_prescaler`

## Requirements
- R1: `instr_en_o` is a one-clock pulse that repeats every 6 clocks. Counting rising clock edges from the first edge after `rst_ni` is released, it is high after edge 7, 13, 19, and so on.
- R2: While `rst_ni` is low, `instr_en_o`, `tmr_tick_o`, `ser_tick_o` and `ckout_o` are low. A new reset restarts the edge sequence of R1 and clears the instruction counter.
- R3: Code value c, with 1 ≤ c ≤ 12 (hex 1 to C), selects division of the instruction rate by 2^c.
- R4: With a legal timer code c, `tmr_tick_o` is a one-clock pulse that is high exactly after edges 6·m·2^c + 2, for m = 1, 2, …
- R5: `ser_tick_o` follows the rule of R4, using its own code `ser_code_i`.
- R6: With a legal clock-output code c, the square-wave level after edge n equals bit c−1 of the instruction count. The instruction count is the number of `instr_en_o` pulses seen before edge n. The wave therefore has a period of 6·2^c clocks and 50% duty.
- R7: Codes 0, 13, 14 and 15 are illegal. An illegal timer or serial code gives no pulse at all. An illegal clock-output code holds `ckout_o` low.
- R8: While `ser_mode_i` is high, `ckout_oe_o` is low and `ckout_o` is low. While it is low, `ckout_oe_o` is high.
- R9: The three taps act independently, so different codes applied at the same time each give their own rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmr_code_i | input | 4 | Division code for the timer tap |
| ser_code_i | input | 4 | Division code for the serial shift tap |
| ckout_code_i | input | 4 | Division code for the clock-output tap |
| ser_mode_i | input | 1 | High when the shared pad carries the serial clock |
| instr_en_o | output | 1 | Instruction-cycle enable pulse |
| tmr_tick_o | output | 1 | Timer count enable pulse |
| ser_tick_o | output | 1 | Serial shift enable pulse |
| ckout_o | output | 1 | Square wave for the clock-output pad |
| ckout_oe_o | output | 1 | Output enable for the clock-output pad |

## Verification
The embedded properties check four things on every cycle:
- the phase counter stays in range and the instruction enable never lasts two clocks;
- the instruction counter moves only on that enable, and by exactly one;
- every tap pulse or square-wave change follows an enable;
- an illegal code silences its tap.

Properties cannot show the exact edge numbers of each pulse, the square-wave level at each edge, or the behaviour after reset. The bench scenarios cover these by comparing the outputs against closed-form edge formulas. Those scenarios use the fastest and slowest ratios, illegal codes, serial-pad mode and a reset during operation.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  typedef enum logic {
    TAP_PULSE  = 1'b0,
    TAP_SQUARE = 1'b1
  } tap_mode_e;

  // a code is usable when it names one of the counter stages
  function automatic logic code_legal(input int code, input int n_stages);
    return (code >= 1) && (code <= n_stages);
  endfunction

endpackage

// File: rtl/icyc_rst_sync.sv
module icyc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/icyc_phase_div.sv
module icyc_phase_div #(
  parameter int DIV = 6,
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic instr_en_o
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;
  logic            wrap;

  always_comb begin
    wrap = (ph_q == PH_LAST);
    ph_d = wrap ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assign instr_en_o = wrap;

  assert_phase_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= PH_LAST);

  assert_enable_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_en_o |=> !instr_en_o);

endmodule

// File: rtl/icyc_ripple_cnt.sv
module icyc_ripple_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_en_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (instr_en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(instr_en_i) |-> $stable(cnt_q));

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(instr_en_i) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/icyc_tap.sv
module icyc_tap
  import icyc_pkg::*;
#(
  parameter int        CNT_W  = 12,
  parameter int        CODE_W = 4,
  parameter tap_mode_e MODE   = TAP_PULSE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tap_o
);

  logic             legal;
  logic [CNT_W-1:0] mask;
  logic             hit;
  logic             tap_q;
  logic             tap_d;
  int               span;

  // a pulse tap fires on the carry out of stage c-1, a square tap
  // toggles on the carry into stage c-1
  always_comb begin
    legal = code_legal(int'(code_i), CNT_W);
    span  = (MODE == TAP_PULSE) ? int'(code_i) : int'(code_i) - 1;
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i < span);
    end
    hit = legal && instr_en_i && ((cnt_i & mask) == mask);
  end

  generate
    if (MODE == TAP_PULSE) begin : g_pulse
      always_comb begin
        tap_d = hit;
      end
    end else begin : g_square
      always_comb begin
        tap_d = legal ? (tap_q ^ hit) : 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= 1'b0;
    else         tap_q <= tap_d;
  end

  assign tap_o = tap_q;

  assert_illegal_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!legal) |-> !tap_q);

  generate
    if (MODE == TAP_PULSE) begin : g_pulse_chk
      assert_tick_on_instr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tap_q |-> $past(instr_en_i));
      assert_tick_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tap_q |=> !tap_q);
    end else begin : g_square_chk
      assert_wave_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tap_q != $past(tap_q)) |-> ($past(instr_en_i) || $past(!legal)));
    end
  endgenerate

endmodule

// File: rtl/icyc_prescaler.sv
module icyc_prescaler
  import icyc_pkg::*;
#(
  parameter int OSC_DIV    = 6,
  parameter int CNT_W      = 12,
  parameter int CODE_W     = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] tmr_code_i,
  input  logic [CODE_W-1:0] ser_code_i,
  input  logic [CODE_W-1:0] ckout_code_i,
  input  logic              ser_mode_i,
  output logic              instr_en_o,
  output logic              tmr_tick_o,
  output logic              ser_tick_o,
  output logic              ckout_o,
  output logic              ckout_oe_o
);

  localparam int N_TAPS = 3;
  localparam int TAP_TMR = 0;
  localparam int TAP_SER = 1;
  localparam int TAP_CK  = 2;

  logic                           rst_n_sync;
  logic                           instr_en;
  logic [CNT_W-1:0]               cnt;
  logic [N_TAPS-1:0][CODE_W-1:0]  codes;
  logic [N_TAPS-1:0]              taps;

  icyc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_sync)
  );

  icyc_phase_div #(.DIV(OSC_DIV)) u_phase_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .instr_en_o (instr_en)
  );

  icyc_ripple_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .instr_en_i (instr_en),
    .cnt_o      (cnt)
  );

  always_comb begin
    codes[TAP_TMR] = tmr_code_i;
    codes[TAP_SER] = ser_code_i;
    codes[TAP_CK]  = ckout_code_i;
  end

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    icyc_tap #(
      .CNT_W  (CNT_W),
      .CODE_W (CODE_W),
      .MODE   ((t == TAP_CK) ? TAP_SQUARE : TAP_PULSE)
    ) u_tap (
      .clk_i      (clk_i),
      .rst_ni     (rst_n_sync),
      .instr_en_i (instr_en),
      .cnt_i      (cnt),
      .code_i     (codes[t]),
      .tap_o      (taps[t])
    );
  end

  assign instr_en_o = instr_en;
  assign tmr_tick_o = taps[TAP_TMR];
  assign ser_tick_o = taps[TAP_SER];
  assign ckout_oe_o = !ser_mode_i;
  assign ckout_o    = taps[TAP_CK] && !ser_mode_i;

  assert_pad_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_mode_i |-> (!ckout_o && !ckout_oe_o));

endmodule

// File: tb/icyc_prescaler_tb.sv
module icyc_prescaler_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] tmr_code, ser_code, ck_code;
  logic       ser_mode;
  logic       instr_en, tmr_tick, ser_tick, ckout, ckout_oe;

  int  n;
  int  tests = 0;
  int  fails = 0;
  int  tq[$];
  int  sq[$];
  bit  mon_on = 1'b0;
  int  cur_ck;
  bit  cur_sel;
  string ck_req;

  always #2.5 clk = ~clk;

  icyc_prescaler u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tmr_code_i   (tmr_code),
    .ser_code_i   (ser_code),
    .ckout_code_i (ck_code),
    .ser_mode_i   (ser_mode),
    .instr_en_o   (instr_en),
    .tmr_tick_o   (tmr_tick),
    .ser_tick_o   (ser_tick),
    .ckout_o      (ckout),
    .ckout_oe_o   (ckout_oe)
  );

  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else        n <= n + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  function automatic bit legal(input int c);
    return (c >= 1) && (c <= 12);
  endfunction

  function automatic int exp_ck(input int nn, input int c, input bit sel);
    int cnt;
    if (!legal(c) || sel || nn < 8) return 0;
    cnt = (nn - 8) / 6 + 1;
    return (cnt >> (c - 1)) & 1;
  endfunction

  // monitor: compares observed pulses against the scoreboard queues
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      bit et, es, ei;
      et = (tq.size() > 0) && (tq[0] == n);
      if (et) void'(tq.pop_front());
      es = (sq.size() > 0) && (sq[0] == n);
      if (es) void'(sq.pop_front());
      ei = (n >= 7) && ((n - 7) % 6 == 0);
      if (et || tmr_tick) check(tmr_tick == et, "R4 timer tick", tmr_tick, et);
      if (es || ser_tick) check(ser_tick == es, "R5 serial tick", ser_tick, es);
      if (ei || instr_en) check(instr_en == ei, "R1 instr enable", instr_en, ei);
      check(ckout == exp_ck(n, cur_ck, cur_sel), ck_req, ckout, exp_ck(n, cur_ck, cur_sel));
      check(ckout_oe == !cur_sel, "R8 pad enable", ckout_oe, !cur_sel);
    end
  end

  // driver: sets codes, resets, loads expected pulse edges, runs
  task automatic run_case(input int tc, input int sc, input int cc, input bit sel,
                          input int len, input string rq);
    @(negedge clk);
    mon_on   = 1'b0;
    rst_n    = 1'b0;
    tmr_code = 4'(tc);
    ser_code = 4'(sc);
    ck_code  = 4'(cc);
    ser_mode = sel;
    cur_ck   = cc;
    cur_sel  = sel;
    ck_req   = rq;
    tq.delete();
    sq.delete();
    repeat (3) @(negedge clk);
    check(!instr_en && !tmr_tick && !ser_tick && !ckout, "R2 reset outputs",
          {instr_en, tmr_tick, ser_tick, ckout}, 0);
    if (legal(tc))
      for (int m = 1; 6 * m * (1 << tc) + 2 <= len; m++) tq.push_back(6 * m * (1 << tc) + 2);
    if (legal(sc))
      for (int m = 1; 6 * m * (1 << sc) + 2 <= len; m++) sq.push_back(6 * m * (1 << sc) + 2);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    repeat (len) @(negedge clk);
    mon_on = 1'b0;
    check(tq.size() == 0, "R4 missing timer ticks", tq.size(), 0);
    check(sq.size() == 0, "R5 missing serial ticks", sq.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    tmr_code = 4'd1; ser_code = 4'd1; ck_code = 4'd1; ser_mode = 1'b0;
    // R3 R9: fastest timer, 1/8 serial, 1/4 clock-out together
    run_case(1, 3, 2, 1'b0, 800, "R6 square wave");
    // R7: illegal serial and clock-out codes, slowest timer ratio
    run_case(12, 0, 15, 1'b0, 24700, "R7 illegal clock-out");
    // R8 R7: serial pad mode hides the wave, timer code 13 silent
    run_case(13, 5, 1, 1'b1, 500, "R8 pad held low");
    // R6: slow clock-out, equal timer and serial codes, code 14 not used
    run_case(4, 4, 12, 1'b0, 400, "R6 slow wave");
    run_case(2, 14, 1, 1'b0, 300, "R6 fastest wave");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule